// File: doc/BRIEF.md
# Paged Packet Buffer Ring Manager

This block produces the byte addresses at which packets are stored in a paged packet memory. The memory holds two circular buffers. One is a transmit ring and the other is a receive ring, and they sit back to back. Every page is 256 bytes, and a byte address is the page number times 256 plus the offset inside the page. Three page registers set the layout. A transmit base page marks where the transmit ring starts. A split page is the first receive page, and the page just below it is the last transmit page. A receive top page is the last receive page. Each ring wraps from its last page back to its first.

Packets arrive one byte per cycle on a stream port for each ring. Each packet starts on a fresh page at offset 4 and runs onto the following pages as needed. The unused tail of its last page is left empty. Once the last byte has been taken, a 4-byte header is written at offsets 0 to 3 of the packet's first page. The header gives the packet length, the next free page and a status byte.

The consumer frees pages by writing a new read page for a ring. A packet that would run into unfreed pages is dropped and flagged. The layout registers can only be changed while both rings are empty and no packet is in progress.

A single write engine serves both rings and has four states:

- IDLE waits for a packet and picks a ring.
- DATA stores payload bytes.
- HDR writes the four header bytes.
- DROP swallows a packet that does not fit.

Its transitions are:

- IDLE→DATA when a packet starts and fits.
- IDLE→DROP when a packet starts but its first page is not free.
- DATA→HDR on the last byte.
- DATA→DROP when a new page is needed but not free and more bytes follow.
- DATA→IDLE when that happens on the last byte.
- HDR→IDLE after the fourth header byte.
- DROP→IDLE on the last byte.

Top module: `pgring_top`

## Requirements
- R1: After reset both rings are empty, the transmit base page is 0x00, the split page is 0x40, the receive top page is 0xFF, and the first transmit packet is stored from page 0x00.
- R2: Every stored byte goes to address page*256+offset. Payload byte k of a packet goes to offset 4+k of its first page while that fits. Later bytes fill the following pages from offset 0.
- R3: After the last payload byte, four header writes follow on consecutive cycles, to offsets 0,1,2,3 of the first page. They carry, in order, the length low byte, the length high byte, the next free page and the status byte. The status byte has bit 0 set, bit 7 = 1 for the receive ring, and the other bits zero.
- R4: The transmit ring runs from the base page to split-1 and wraps from split-1 back to the base page.
- R5: The receive ring runs from the split page to the top page inclusive and wraps from the top page back to the split page.
- R6: Each packet starts at offset 4 of the ring's write page. After the header, the write page becomes the page after the packet's last page, even if that last page was only partly filled.
- R7: A packet is dropped if its first page, or any later page it needs, is the page whose next page is the read page. A dropped packet gets no header and leaves the write page unchanged. The ring's overflow output pulses for one cycle, in the cycle after its last byte is accepted.
- R8: A ring's empty output is high exactly when its write page equals its read page. A read-page write takes effect on the next cycle.
- R9: A layout write takes effect only when both rings are empty and no packet is in progress. Otherwise it is ignored. Select 0 = transmit base, 1 = split, 2 = receive top. An accepted write moves the affected ring's write and read pages to its new start page.
- R10: When both rings present a packet in the same cycle, the transmit packet is stored first. Packets are never interleaved.
- R11: At most one ring's ready is high in any cycle. Ready is high only while the engine is storing or dropping that ring's packet, and one byte is accepted per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Layout register write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 split, 2 top |
| cfg_wdata | input | 8 | Page value to write |
| tx_valid | input | 1 | Transmit byte valid |
| tx_data | input | 8 | Transmit byte |
| tx_last | input | 1 | Last byte of transmit packet |
| tx_ready | output | 1 | Transmit byte accepted this cycle when valid |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Last byte of receive packet |
| rx_ready | output | 1 | Receive byte accepted this cycle when valid |
| tx_rd_we | input | 1 | Load transmit read page |
| tx_rd_page | input | 8 | New transmit read page |
| rx_rd_we | input | 1 | Load receive read page |
| rx_rd_page | input | 8 | New receive read page |
| tx_empty | output | 1 | Transmit ring holds no packets |
| rx_empty | output | 1 | Receive ring holds no packets |
| tx_ovf | output | 1 | Transmit packet dropped (one-cycle pulse) |
| rx_ovf | output | 1 | Receive packet dropped (one-cycle pulse) |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |

## Verification
The embedded properties check on every cycle that:
- Only one ring is ready at a time.
- The four header writes run without a break.
- Payload never lands on the header bytes of the first page.
- A committed packet moves the write page to the announced next free page.
- An overflow pulse lasts a single cycle.
- An accepted layout write leaves both rings empty.

Only the bench scenarios can show that addresses wrap at the right page for each ring. The same holds for the length and next-page values in the header. The scenarios also show that a full ring drops packets both at the start and in the middle, that a blocked layout write changes nothing, and that transmit wins when both rings start together.

// File: rtl/pgring_pkg.sv
package pgring_pkg;

    localparam int OFF_BITS = 8;
    localparam int HDR_BYTES = 4;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_DATA,
        WS_HDR,
        WS_DROP
    } wr_state_e;

    typedef enum logic [1:0] {
        CFG_TX_BASE  = 2'd0,
        CFG_SPLIT    = 2'd1,
        CFG_RX_TOP   = 2'd2,
        CFG_RESERVED = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/pgring_step.sv
module pgring_step #(
    parameter int PAGE_BITS = 8
) (
    input  logic [PAGE_BITS-1:0] page,
    input  logic [PAGE_BITS-1:0] first,
    input  logic [PAGE_BITS-1:0] last,
    output logic [PAGE_BITS-1:0] nxt
);
    // page following 'page' inside the ring [first..last]
    assign nxt = (page == last) ? first : page + 1'b1;
endmodule

// File: rtl/pgring_ring.sv
module pgring_ring #(
    parameter int PAGE_BITS = 8,
    parameter int RST_PAGE  = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [PAGE_BITS-1:0] load_page,
    input  logic                 commit,
    input  logic [PAGE_BITS-1:0] commit_page,
    input  logic                 rd_we,
    input  logic [PAGE_BITS-1:0] rd_in,
    output logic [PAGE_BITS-1:0] wr_page,
    output logic [PAGE_BITS-1:0] rd_page,
    output logic                 empty
);
    logic [PAGE_BITS-1:0] wr_q, rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= PAGE_BITS'(RST_PAGE);
            rd_q <= PAGE_BITS'(RST_PAGE);
        end else if (load) begin
            wr_q <= load_page;
            rd_q <= load_page;
        end else begin
            if (commit) wr_q <= commit_page;
            if (rd_we)  rd_q <= rd_in;
        end
    end

    assign wr_page = wr_q;
    assign rd_page = rd_q;
    assign empty   = (wr_q == rd_q);

    // R6: a commit moves the write page to the announced next free page
    a_r6_commit_adv: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !load) |=> (wr_q == $past(commit_page)));
endmodule

// File: rtl/pgring_writer.sv
module pgring_writer
    import pgring_pkg::*;
#(
    parameter int PAGE_BITS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_hold,
    input  logic [1:0]                s_valid,
    input  logic [1:0]                s_last,
    input  logic [1:0][7:0]           s_data,
    output logic [1:0]                s_ready,
    input  logic [1:0][PAGE_BITS-1:0] ring_first,
    input  logic [1:0][PAGE_BITS-1:0] ring_last,
    input  logic [1:0][PAGE_BITS-1:0] wr_page,
    input  logic [1:0][PAGE_BITS-1:0] rd_page,
    output logic [1:0]                commit,
    output logic [PAGE_BITS-1:0]      commit_page,
    output logic [1:0]                ovf,
    output logic                      idle,
    output logic                      mem_we,
    output logic [PAGE_BITS+OFF_BITS-1:0] mem_addr,
    output logic [7:0]                mem_wdata
);
    wr_state_e st_q, st_d;

    logic                 sel_q;
    logic [PAGE_BITS-1:0] first_q, cp_q;
    logic [OFF_BITS-1:0]  off_q;
    logic                 full_q;
    logic [15:0]          len_q;
    logic [1:0]           dcnt_q;
    logic [1:0]           ovf_q;

    logic                 pick, any_start, start_full, take, grow_fail;
    logic [PAGE_BITS-1:0] st_nx, nx1, nx2;

    assign pick      = s_valid[0] ? 1'b0 : 1'b1;
    assign any_start = |s_valid;

    pgring_step #(.PAGE_BITS(PAGE_BITS)) u_start (
        .page(wr_page[pick]), .first(ring_first[pick]), .last(ring_last[pick]), .nxt(st_nx));
    pgring_step #(.PAGE_BITS(PAGE_BITS)) u_nx1 (
        .page(cp_q), .first(ring_first[sel_q]), .last(ring_last[sel_q]), .nxt(nx1));
    pgring_step #(.PAGE_BITS(PAGE_BITS)) u_nx2 (
        .page(nx1), .first(ring_first[sel_q]), .last(ring_last[sel_q]), .nxt(nx2));

    assign start_full = (st_nx == rd_page[pick]);
    assign take       = s_valid[sel_q] && (st_q == WS_DATA || st_q == WS_DROP);
    assign grow_fail  = full_q && (nx2 == rd_page[sel_q]);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= WS_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WS_IDLE: if (!start_hold && any_start)
                         st_d = start_full ? WS_DROP : WS_DATA;
            WS_DATA: if (take) begin
                         if (grow_fail)           st_d = s_last[sel_q] ? WS_IDLE : WS_DROP;
                         else if (s_last[sel_q])  st_d = WS_HDR;
                     end
            WS_HDR:  if (dcnt_q == 2'd3) st_d = WS_IDLE;
            WS_DROP: if (take && s_last[sel_q]) st_d = WS_IDLE;
            default: st_d = WS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        s_ready     = '0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        commit      = '0;
        commit_page = nx1;
        unique case (st_q)
            WS_IDLE: ;
            WS_DATA: begin
                s_ready[sel_q] = 1'b1;
                if (s_valid[sel_q] && !grow_fail) begin
                    mem_we    = 1'b1;
                    mem_addr  = full_q ? {nx1, {OFF_BITS{1'b0}}} : {cp_q, off_q};
                    mem_wdata = s_data[sel_q];
                end
            end
            WS_HDR: begin
                mem_we   = 1'b1;
                mem_addr = {first_q, {(OFF_BITS-2){1'b0}}, dcnt_q};
                unique case (dcnt_q)
                    2'd0:    mem_wdata = len_q[7:0];
                    2'd1:    mem_wdata = len_q[15:8];
                    2'd2:    mem_wdata = 8'(nx1);
                    default: mem_wdata = {sel_q, 6'b0, 1'b1};
                endcase
                if (dcnt_q == 2'd3) commit[sel_q] = 1'b1;
            end
            WS_DROP: s_ready[sel_q] = 1'b1;
            default: ;
        endcase
    end

    // packet datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            first_q <= '0;
            cp_q    <= '0;
            off_q   <= '0;
            full_q  <= 1'b0;
            len_q   <= '0;
            dcnt_q  <= '0;
            ovf_q   <= '0;
        end else begin
            ovf_q <= '0;
            if (st_q == WS_IDLE && !start_hold && any_start) begin
                sel_q   <= pick;
                first_q <= wr_page[pick];
                cp_q    <= wr_page[pick];
                off_q   <= OFF_BITS'(HDR_BYTES);
                full_q  <= 1'b0;
                len_q   <= '0;
                dcnt_q  <= '0;
            end
            if (st_q == WS_DATA && take) begin
                if (grow_fail) begin
                    if (s_last[sel_q]) ovf_q[sel_q] <= 1'b1;
                end else begin
                    if (full_q) begin
                        cp_q   <= nx1;
                        off_q  <= OFF_BITS'(1);
                        full_q <= 1'b0;
                    end else begin
                        off_q  <= off_q + 1'b1;
                        full_q <= (off_q == {OFF_BITS{1'b1}});
                    end
                    len_q <= len_q + 16'd1;
                end
            end
            if (st_q == WS_DROP && take && s_last[sel_q]) ovf_q[sel_q] <= 1'b1;
            if (st_q == WS_HDR) dcnt_q <= dcnt_q + 2'd1;
        end
    end

    assign ovf  = ovf_q;
    assign idle = (st_q == WS_IDLE);

    // R11: never two rings ready at once
    a_r11_one_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_ready));
    // R3: header writes are back to back
    a_r3_hdr_run: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WS_HDR && dcnt_q != 2'd3) |=> (st_q == WS_HDR && mem_we));
    // R2: payload never lands on the header bytes
    a_r2_payload_off: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WS_DATA && mem_we && mem_addr[PAGE_BITS+OFF_BITS-1:OFF_BITS] == first_q)
        |-> (mem_addr[OFF_BITS-1:0] >= OFF_BITS'(HDR_BYTES)));
    // R7: overflow is a single-cycle pulse
    a_r7_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q != 2'b00) |=> (ovf_q == 2'b00));
endmodule

// File: rtl/pgring_top.sv
module pgring_top
    import pgring_pkg::*;
#(
    parameter int PAGE_BITS   = 8,
    parameter int TX_BASE_RST = 8'h00,
    parameter int SPLIT_RST   = 8'h40,
    parameter int RX_TOP_RST  = 8'hFF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [1:0]                    cfg_sel,
    input  logic [PAGE_BITS-1:0]          cfg_wdata,
    input  logic                          tx_valid,
    input  logic [7:0]                    tx_data,
    input  logic                          tx_last,
    output logic                          tx_ready,
    input  logic                          rx_valid,
    input  logic [7:0]                    rx_data,
    input  logic                          rx_last,
    output logic                          rx_ready,
    input  logic                          tx_rd_we,
    input  logic [PAGE_BITS-1:0]          tx_rd_page,
    input  logic                          rx_rd_we,
    input  logic [PAGE_BITS-1:0]          rx_rd_page,
    output logic                          tx_empty,
    output logic                          rx_empty,
    output logic                          tx_ovf,
    output logic                          rx_ovf,
    output logic                          mem_we,
    output logic [PAGE_BITS+OFF_BITS-1:0] mem_addr,
    output logic [7:0]                    mem_wdata
);
    localparam int NRING = 2;

    logic [PAGE_BITS-1:0] base_q, split_q, top_q;
    logic                 idle, cfg_accept;

    logic [NRING-1:0]                s_valid, s_last, s_ready, commit, ovf, empty, rd_we, load;
    logic [NRING-1:0][7:0]           s_data;
    logic [NRING-1:0][PAGE_BITS-1:0] ring_first, ring_last, wr_page, rd_page, rd_in, load_page;
    logic [PAGE_BITS-1:0]            commit_page;

    assign s_valid = {rx_valid, tx_valid};
    assign s_last  = {rx_last,  tx_last};
    assign s_data  = {rx_data,  tx_data};
    assign rd_we   = {rx_rd_we, tx_rd_we};
    assign rd_in   = {rx_rd_page, tx_rd_page};

    assign cfg_accept = cfg_we && empty[0] && empty[1] && idle;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= PAGE_BITS'(TX_BASE_RST);
            split_q <= PAGE_BITS'(SPLIT_RST);
            top_q   <= PAGE_BITS'(RX_TOP_RST);
        end else if (cfg_accept) begin
            unique case (cfg_sel)
                CFG_TX_BASE: base_q  <= cfg_wdata;
                CFG_SPLIT:   split_q <= cfg_wdata;
                CFG_RX_TOP:  top_q   <= cfg_wdata;
                default: ;
            endcase
        end
    end

    assign ring_first[0] = base_q;
    assign ring_last[0]  = split_q - 1'b1;
    assign ring_first[1] = split_q;
    assign ring_last[1]  = top_q;

    assign load_page[0] = (cfg_sel == CFG_TX_BASE) ? cfg_wdata : base_q;
    assign load_page[1] = (cfg_sel == CFG_SPLIT)   ? cfg_wdata : split_q;
    assign load         = {NRING{cfg_accept}};

    for (genvar g = 0; g < NRING; g++) begin : g_ring
        pgring_ring #(
            .PAGE_BITS(PAGE_BITS),
            .RST_PAGE (g == 0 ? TX_BASE_RST : SPLIT_RST)
        ) u_ring (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load[g]),
            .load_page  (load_page[g]),
            .commit     (commit[g]),
            .commit_page(commit_page),
            .rd_we      (rd_we[g]),
            .rd_in      (rd_in[g]),
            .wr_page    (wr_page[g]),
            .rd_page    (rd_page[g]),
            .empty      (empty[g])
        );
    end

    pgring_writer #(.PAGE_BITS(PAGE_BITS)) u_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_hold (cfg_accept),
        .s_valid    (s_valid),
        .s_last     (s_last),
        .s_data     (s_data),
        .s_ready    (s_ready),
        .ring_first (ring_first),
        .ring_last  (ring_last),
        .wr_page    (wr_page),
        .rd_page    (rd_page),
        .commit     (commit),
        .commit_page(commit_page),
        .ovf        (ovf),
        .idle       (idle),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    assign tx_ready = s_ready[0];
    assign rx_ready = s_ready[1];
    assign tx_empty = empty[0];
    assign rx_empty = empty[1];
    assign tx_ovf   = ovf[0];
    assign rx_ovf   = ovf[1];

    // R9: an accepted layout write leaves both rings empty
    a_r9_cfg_resets: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_accept |=> (tx_empty && rx_empty));
endmodule

// File: tb/pgring_top_tb_top.sv
`timescale 1ns/1ps
module pgring_top_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        tx_valid = 1'b0, tx_last = 1'b0, rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  tx_data = '0, rx_data = '0;
    logic        tx_ready, rx_ready;
    logic        tx_rd_we = 1'b0, rx_rd_we = 1'b0;
    logic [7:0]  tx_rd_page = '0, rx_rd_page = '0;
    logic        tx_empty, rx_empty, tx_ovf, rx_ovf, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;

    pgring_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
        .tx_rd_we(tx_rd_we), .tx_rd_page(tx_rd_page), .rx_rd_we(rx_rd_we), .rx_rd_page(rx_rd_page),
        .tx_empty(tx_empty), .rx_empty(rx_empty), .tx_ovf(tx_ovf), .rx_ovf(rx_ovf),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

    typedef struct { int addr; int data; string tag; } wr_t;
    wr_t expq[$];

    int n_chk = 0, n_fail = 0;
    int m_first[2], m_last[2], m_w[2], m_r[2];
    int m_base = 'h00, m_split = 'h40, m_top = 'hFF;
    bit ovf_seen[2], exp_ovf[2];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void relayout();
        m_first[0] = m_base;  m_last[0] = (m_split - 1) & 255;
        m_first[1] = m_split; m_last[1] = m_top;
    endfunction

    function automatic int nxt(input int r, input int p);
        if (p == m_last[r]) return m_first[r];
        return (p + 1) & 255;
    endfunction

    // reference model: builds the expected write list for one packet
    task automatic expect_pkt(input int r, input int n, input int seed, input string tag);
        int cp, off, fw;
        bit ov;
        fw = m_w[r];
        ov = 1'b0;
        if (nxt(r, fw) == m_r[r]) ov = 1'b1;
        else begin
            cp = fw; off = 4;
            for (int i = 0; i < n; i++) begin
                if (off == 256) begin
                    if (nxt(r, nxt(r, cp)) == m_r[r]) begin ov = 1'b1; break; end
                    cp = nxt(r, cp); off = 0;
                end
                expq.push_back('{cp*256 + off, (seed + i) & 255, tag});
                off++;
            end
            if (!ov) begin
                expq.push_back('{fw*256 + 0, n & 255, "R3 len lo"});
                expq.push_back('{fw*256 + 1, (n >> 8) & 255, "R3 len hi"});
                expq.push_back('{fw*256 + 2, nxt(r, cp), "R3 next page"});
                expq.push_back('{fw*256 + 3, (r == 1) ? 'h81 : 'h01, "R3 status"});
                m_w[r] = nxt(r, cp);
            end
        end
        exp_ovf[r] = ov;
    endtask

    task automatic drive_pkt(input int r, input int n, input int seed);
        int i;
        bit rdy;
        i = 0;
        while (i < n) begin
            @(negedge clk);
            if (r == 0) begin tx_valid = 1'b1; tx_data = 8'((seed + i) & 255); tx_last = (i == n-1); rdy = tx_ready; end
            else        begin rx_valid = 1'b1; rx_data = 8'((seed + i) & 255); rx_last = (i == n-1); rdy = rx_ready; end
            if (rdy) i++;
        end
        @(negedge clk);
        if (r == 0) begin tx_valid = 1'b0; tx_last = 1'b0; end
        else        begin rx_valid = 1'b0; rx_last = 1'b0; end
    endtask

    task automatic settle(input string tag);
        repeat (8) @(negedge clk);
        check(expq.size() == 0, tag, expq.size(), 0);
        for (int r = 0; r < 2; r++) begin
            check(ovf_seen[r] == exp_ovf[r], "R7 overflow flag", ovf_seen[r], exp_ovf[r]);
            ovf_seen[r] = 1'b0;
            exp_ovf[r]  = 1'b0;
        end
        check(tx_empty == (m_w[0] == m_r[0]), "R8 tx empty", tx_empty, m_w[0] == m_r[0]);
        check(rx_empty == (m_w[1] == m_r[1]), "R8 rx empty", rx_empty, m_w[1] == m_r[1]);
    endtask

    task automatic send(input int r, input int n, input int seed, input string tag);
        expect_pkt(r, n, seed, tag);
        drive_pkt(r, n, seed);
        settle(tag);
    endtask

    task automatic set_cfg(input int sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = 8'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        if (m_w[0] == m_r[0] && m_w[1] == m_r[1]) begin
            if (sel == 0) m_base = val;
            else if (sel == 1) m_split = val;
            else if (sel == 2) m_top = val;
            relayout();
            m_w[0] = m_base;  m_r[0] = m_base;
            m_w[1] = m_split; m_r[1] = m_split;
        end
    endtask

    task automatic release_pg(input int r, input int p);
        @(negedge clk);
        if (r == 0) begin tx_rd_we = 1'b1; tx_rd_page = 8'(p); end
        else        begin rx_rd_we = 1'b1; rx_rd_page = 8'(p); end
        @(negedge clk);
        tx_rd_we = 1'b0; rx_rd_we = 1'b0;
        m_r[r] = p;
    endtask

    // per-clock comparison of the memory port against the model
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (tx_ovf) ovf_seen[0] = 1'b1;
            if (rx_ovf) ovf_seen[1] = 1'b1;
            if (mem_we) begin
                if (expq.size() == 0) check(1'b0, "R2 unexpected write", int'(mem_addr), -1);
                else begin
                    wr_t e;
                    e = expq.pop_front();
                    check(int'(mem_addr) == e.addr && int'(mem_wdata) == e.data, e.tag,
                          {mem_addr, mem_wdata}, (e.addr << 8) | e.data);
                end
            end
        end
    end

    bit done = 1'b0;
    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        relayout();
        m_w[0] = m_base; m_r[0] = m_base; m_w[1] = m_split; m_r[1] = m_split;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(tx_empty && rx_empty, "R1 both empty", {tx_empty, rx_empty}, 3);
        check(!mem_we && !tx_ovf && !rx_ovf, "R1 quiet", {mem_we, tx_ovf, rx_ovf}, 0);
        check(!tx_ready && !rx_ready, "R11 no ready when idle", {tx_ready, rx_ready}, 0);
        send(0, 3, 'h11, "R1 default tx page");
        // R9: blocked layout write while tx ring is not empty
        set_cfg(0, 'h10);
        send(0, 5, 'h20, "R9 write ignored");
        release_pg(0, 2);
        check(tx_empty, "R8 release empties", tx_empty, 1);
        set_cfg(0, 'h10); set_cfg(1, 'h14); set_cfg(2, 'h17);
        check(tx_empty && rx_empty, "R9 layout reset", {tx_empty, rx_empty}, 3);
        send(0, 10, 'h30, "R6 new page");
        send(0, 300, 'h40, "R2 multi page");
        send(0, 20, 'h50, "R7 full at start");
        release_pg(0, 'h13);
        check(tx_empty, "R8 tx empty after release", tx_empty, 1);
        send(0, 600, 'h60, "R4 tx wrap");
        send(1, 252, 'h70, "R6 exact page");
        send(1, 253, 'h80, "R2 one byte over");
        release_pg(1, 'h15);
        send(1, 300, 'h90, "R7 mid packet drop");
        release_pg(1, 'h17);
        send(1, 300, 'hA0, "R5 rx wrap");
        release_pg(0, m_w[0]);
        // R10: both start together, tx first
        expect_pkt(0, 8, 'hB0, "R10 tx first");
        expect_pkt(1, 8, 'hC0, "R10 rx second");
        fork
            drive_pkt(0, 8, 'hB0);
            drive_pkt(1, 8, 'hC0);
        join
        settle("R10 arbitration");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule